// File: doc/BRIEF.md
# Debug Module Run-Control Registers

This block holds the run-control and status registers of a debug module that serves one hart. A debug transport issues requests on a simple request/response port: a valid strobe, an address, a read/write flag and write data. Every request gets an answer one cycle later. The control register drives three outputs. The first activates the debug module. The second asks the hart to halt. The third asks for a reset of the rest of the system, leaving the debug logic alone.

The status register is built on the fly at read time. It takes a hart availability input, and a halted flag that the hart side sets with a one-cycle strobe and clears with a resume strobe. Other debug registers sit outside this block. The block only grants them a write enable, and only while the module is active.

Top module: `dmcs_top`

## Requirements
- R1: A write to the control register (address 0x10) loads bit 0 into `dmactive_o`. The output changes in the cycle after the write request.
- R2: While the module is active, a write to the control register loads bit 31 into `debug_req_o`.
- R3: While the module is active, a write to the control register loads bit 1 into `ndmreset_o`. The output stays high until a later write clears bit 1.
- R4: While `dmactive_o` is 0, a control write sets only the active bit. Bits 31 and 1 are dropped, even when the same write sets bit 0. Writes to any other address leave `regs_we_o` low.
- R5: A control write with bit 0 cleared drops `debug_req_o`, `ndmreset_o` and the halted flag to 0.
- R6: A read of the status register (address 0x11) returns `unavail_i`, as sampled in the request cycle, in both bit 13 and bit 12.
- R7: The status register shows the halted flag in both bit 9 and bit 8. The flag is set by `halted_set_i` while active and cleared by `resume_i`. A set strobe wins over a resume strobe in the same cycle.
- R8: While `ndmreset_o` is high, the control and status contents stay as they were. The halted flag and the readback fields do not change.
- R9: Every request is answered in the following cycle, with `resp_valid_o` high and `resp_err_o` low. Reads of any address other than 0x10 and 0x11 return zero.
- R10: A control read returns haltreq in bit 31, ndmreset in bit 1 and dmactive in bit 0. All other bits read as 0. Status bits 3:0 hold the version parameter (default 2). Status bits not named in R6 and R7 read as 0.
- R11: While active, a write to any address other than 0x10 and 0x11 raises `regs_we_o` in the same cycle as the request. Writes to 0x11 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Register address |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| resp_rdata_o | output | 32 | Read data |
| resp_err_o | output | 1 | Error flag, always 0 |
| unavail_i | input | 1 | Hart is unavailable |
| halted_set_i | input | 1 | Hart reports that it has halted |
| resume_i | input | 1 | Hart reports that it has resumed |
| dmactive_o | output | 1 | Debug module is active |
| debug_req_o | output | 1 | Halt request to the hart |
| ndmreset_o | output | 1 | Reset request to the rest of the system |
| regs_we_o | output | 1 | Write enable for registers outside this block |

## Verification
Some properties are checked by the assertions on every cycle:
- a halt request or reset request never stands without the active bit;
- write enables never pass while the module is inactive;
- every request is answered in the next cycle;
- a set strobe while active sets the halted flag;
- a status response carries the availability input seen in the request cycle.

Other behaviour only shows up in the bench's scenarios:
- control fields are dropped when the same write also activates the module;
- outputs persist across long sequences;
- deactivation clears the hart-side state;
- contents survive while the system reset is requested.

// File: rtl/dmcs_pkg.sv
package dmcs_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 7'h10;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 7'h11;

  localparam int unsigned CTRL_ACTIVE_BIT = 0;
  localparam int unsigned CTRL_NDMRST_BIT = 1;
  localparam int unsigned CTRL_HALTREQ_BIT = 31;
  localparam int unsigned STAT_ANYHALT_BIT = 8;
  localparam int unsigned STAT_ALLHALT_BIT = 9;
  localparam int unsigned STAT_ANYUNAV_BIT = 12;
  localparam int unsigned STAT_ALLUNAV_BIT = 13;

  typedef struct packed {
    logic active;
    logic haltreq;
    logic ndmreset;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT
  } sel_e;
endpackage

// File: rtl/dmcs_ctrl_reg.sv
module dmcs_ctrl_reg
  import dmcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.active <= wdata_i[CTRL_ACTIVE_BIT];
      // other fields only accepted when already active and staying active
      if (ctrl_q.active && wdata_i[CTRL_ACTIVE_BIT]) begin
        ctrl_q.haltreq  <= wdata_i[CTRL_HALTREQ_BIT];
        ctrl_q.ndmreset <= wdata_i[CTRL_NDMRST_BIT];
      end else begin
        ctrl_q.haltreq  <= 1'b0;
        ctrl_q.ndmreset <= 1'b0;
      end
    end
  end

  assign ctrl_o = ctrl_q;

  // R4
  inactive_no_haltreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.active |=> !ctrl_q.haltreq);
  // R5
  deact_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CTRL_ACTIVE_BIT]) |=> (!ctrl_q.haltreq && !ctrl_q.ndmreset));
endmodule

// File: rtl/dmcs_status.sv
module dmcs_status
  import dmcs_pkg::*;
#(
  parameter int unsigned VERSION = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              halted_set_i,
  input  logic              resume_i,
  input  logic              unavail_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] status_o
);
  logic halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           halted_q <= 1'b0;
    else if (!active_i)    halted_q <= 1'b0;
    else if (halted_set_i) halted_q <= 1'b1;
    else if (resume_i)     halted_q <= 1'b0;
  end

  always_comb begin
    status_o = '0;
    status_o[3:0] = 4'(VERSION);
    status_o[STAT_ANYHALT_BIT] = halted_q;
    status_o[STAT_ALLHALT_BIT] = halted_q;
    status_o[STAT_ANYUNAV_BIT] = unavail_i;
    status_o[STAT_ALLUNAV_BIT] = unavail_i;
  end

  assign halted_o = halted_q;

  // R7
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && halted_set_i) |=> halted_q);
  // R7
  resume_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !halted_set_i) |=> !halted_q);
endmodule

// File: rtl/dmcs_dmi_port.sv
module dmcs_dmi_port
  import dmcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              ctrl_wr_o,
  output logic              ext_wr_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o
);
  sel_e sel;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] ctrl_word;
  logic resp_valid_q;
  logic [DATA_W-1:0] resp_rdata_q;

  always_comb begin
    unique case (req_addr_i)
      ADDR_CTRL: sel = SEL_CTRL;
      ADDR_STAT: sel = SEL_STAT;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_ACTIVE_BIT]  = ctrl_i.active;
    ctrl_word[CTRL_NDMRST_BIT]  = ctrl_i.ndmreset;
    ctrl_word[CTRL_HALTREQ_BIT] = ctrl_i.haltreq;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = ctrl_word;
      SEL_STAT: rdata = status_i;
      default:  rdata = '0;
    endcase
  end

  assign ctrl_wr_o = req_valid_i && req_write_i && (sel == SEL_CTRL);
  assign ext_wr_o  = req_valid_i && req_write_i && (sel == SEL_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= req_valid_i;
      resp_rdata_q <= (req_valid_i && !req_write_i) ? rdata : '0;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_rdata_o = resp_rdata_q;

  // R9
  resp_next_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  // R9
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
endmodule

// File: rtl/dmcs_top.sv
module dmcs_top
  import dmcs_pkg::*;
#(
  parameter int unsigned VERSION = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [6:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        resp_valid_o,
  output logic [31:0] resp_rdata_o,
  output logic        resp_err_o,
  input  logic        unavail_i,
  input  logic        halted_set_i,
  input  logic        resume_i,
  output logic        dmactive_o,
  output logic        debug_req_o,
  output logic        ndmreset_o,
  output logic        regs_we_o
);
  ctrl_t ctrl;
  logic ctrl_wr, ext_wr, halted;
  logic [DATA_W-1:0] status;

  dmcs_dmi_port i_port (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i,
    .ctrl_i(ctrl), .status_i(status),
    .ctrl_wr_o(ctrl_wr), .ext_wr_o(ext_wr),
    .resp_valid_o, .resp_rdata_o
  );

  dmcs_ctrl_reg i_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .wdata_i(req_wdata_i), .ctrl_o(ctrl)
  );

  dmcs_status #(.VERSION(VERSION)) i_stat (
    .clk_i, .rst_ni, .active_i(ctrl.active), .halted_set_i, .resume_i,
    .unavail_i, .halted_o(halted), .status_o(status)
  );

  assign resp_err_o  = 1'b0;
  assign dmactive_o  = ctrl.active;
  assign debug_req_o = ctrl.haltreq;
  assign ndmreset_o  = ctrl.ndmreset;
  assign regs_we_o   = ext_wr && ctrl.active;

  // R2
  req_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_req_o |-> dmactive_o);
  // R3
  ndm_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ndmreset_o |-> dmactive_o);
  // R4
  we_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_we_o |-> (dmactive_o && req_valid_i && req_write_i));
  // R6
  unavail_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == ADDR_STAT)
      |=> (resp_rdata_o[STAT_ALLUNAV_BIT] == $past(unavail_i)));
  // R8
  halted_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ndmreset_o && !halted_set_i && !resume_i && !ctrl_wr) |=> $stable(halted));
endmodule

// File: tb/test_dmcs_top.sv
module test_dmcs_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic unavail = 0, halted_set = 0, resume = 0;
  logic dmactive, debug_req, ndmreset, regs_we;

  int n_chk = 0, n_bad = 0;
  bit m_act = 0, m_hreq = 0, m_ndm = 0, m_halted = 0;

  always #2 clk = ~clk;

  dmcs_top i_dmcs_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .resp_valid_o(resp_valid),
    .resp_rdata_o(resp_rdata), .resp_err_o(resp_err), .unavail_i(unavail),
    .halted_set_i(halted_set), .resume_i(resume), .dmactive_o(dmactive),
    .debug_req_o(debug_req), .ndmreset_o(ndmreset), .regs_we_o(regs_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    return {m_hreq, 29'd0, m_ndm, m_act};
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = 32'd2;
    v[13] = unavail; v[12] = unavail; v[9] = m_halted; v[8] = m_halted;
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    if (a == 7'h10) return exp_ctrl();
    if (a == 7'h11) return exp_stat();
    return 32'd0;
  endfunction

  task automatic dmi(input bit wr, input logic [6:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    logic [31:0] exp_rd;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    exp_rd = wr ? 32'd0 : exp_read(a);
    #1;
    // R11 / R4: write enable is combinational in the request cycle
    check("R11_we", {31'd0, regs_we}, {31'd0, wr && m_act && a != 7'h10 && a != 7'h11});
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (wr && a == 7'h10) begin
      if (m_act && d[0]) begin m_hreq = d[31]; m_ndm = d[1]; end
      else begin m_hreq = 0; m_ndm = 0; end
      m_act = d[0];
      if (!m_act) m_halted = 0;
    end
    rd = resp_rdata;
    check("R9_valid", {30'd0, resp_valid, resp_err}, 32'd2);
    check("R9_R10_rdata", resp_rdata, exp_rd);
    check("R1_R2_R3_outs", {29'd0, dmactive, debug_req, ndmreset}, {29'd0, m_act, m_hreq, m_ndm});
  endtask

  task automatic hart(input bit set, input bit res);
    @(negedge clk);
    halted_set = set; resume = res;
    @(negedge clk);
    halted_set = 0; resume = 0;
    if (m_act) begin
      if (set) m_halted = 1;
      else if (res) m_halted = 0;
    end
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // reset state
    check("R1_reset", {29'd0, dmactive, debug_req, ndmreset}, 32'd0);
    check("R9_reset", {31'd0, resp_valid}, 32'd0);
    rst_n = 1;
    // R4: fields dropped while inactive, even with activation in same write
    dmi(1, 7'h10, 32'h8000_0003, rd);
    check("R4_same_write", {30'd0, debug_req, ndmreset}, 32'd0);
    dmi(1, 7'h22, 32'hdead_beef, rd);
    // R2 R3
    dmi(1, 7'h10, 32'h8000_0003, rd);
    check("R2_haltreq", {31'd0, debug_req}, 32'd1);
    dmi(0, 7'h10, 0, rd);
    // R8: contents held while ndmreset is high
    hart(1, 0);
    repeat (5) @(negedge clk);
    dmi(0, 7'h11, 0, rd);
    check("R8_halted_kept", {31'd0, rd[9]}, 32'd1);
    check("R3_ndm_held", {31'd0, ndmreset}, 32'd1);
    // R6
    unavail = 1;
    dmi(0, 7'h11, 0, rd);
    check("R6_unavail", {30'd0, rd[13], rd[12]}, 32'd3);
    unavail = 0;
    // R11: status write ignored
    dmi(1, 7'h11, 32'hffff_ffff, rd);
    dmi(0, 7'h11, 0, rd);
    // R7: set beats resume
    hart(1, 1);
    dmi(0, 7'h11, 0, rd);
    hart(0, 1);
    dmi(0, 7'h11, 0, rd);
    check("R7_resume", {31'd0, rd[8]}, 32'd0);
    // R5: deactivation clears everything
    dmi(1, 7'h10, 32'h8000_0003, rd);
    hart(1, 0);
    dmi(1, 7'h10, 32'h8000_0002, rd);
    check("R5_cleared", {29'd0, dmactive, debug_req, ndmreset}, 32'd0);
    dmi(0, 7'h11, 0, rd);
    hart(1, 0);
    dmi(0, 7'h11, 0, rd);
    // R9 unmapped read
    dmi(0, 7'h7f, 0, rd);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned k = $urandom_range(0, 7);
      logic [31:0] d = $urandom;
      unavail = $urandom_range(0, 1);
      case (k)
        0, 1: dmi(1, 7'h10, {d[31], 29'd0, d[1], ($urandom_range(0, 3) != 0)}, rd);
        2: dmi(0, 7'h10, 0, rd);
        3: dmi(0, 7'h11, 0, rd);
        4: dmi($urandom_range(0, 1), 7'($urandom), d, rd);
        5: hart(1, $urandom_range(0, 1));
        6: hart(0, 1);
        default: dmi(1, 7'h11, d, rd);
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule